// File: doc/BRIEF.md
# HDLC Receive Frame Validator

This block takes a serial line sampled one bit at a time under a bit enable and recovers HDLC frames from it. It finds the 0x7E flag that bounds each frame and detects runs of seven ones as an abort. It strips the zero that a transmitter inserts after five ones and packs the remaining bits, least significant first, into octets. Every octet of a frame except the final two, which carry the 16-bit frame check sequence, goes out on a one-cycle write strobe toward an external receive FIFO.

When a frame ends, the block sorts it and reports the result. A frame is good, bad-FCS, aborted or invalid. A frame is invalid if it is shorter than the minimum length or does not end on an octet boundary. Invalid frames are still written into the FIFO, but they are never counted as check-sequence errors. There is no upper limit on frame length. Each message end raises a one-cycle interrupt. The 3-bit status and the running octet length hold until software reads them or the next message replaces them.

Top module: `hdlc_rx_validator`

## Requirements
- R1: A flag is the raw pattern 0x7E (bits 0,1,1,1,1,1,1,0 in line order). A flag that follows another flag with no data between them produces no interrupt and no write.
- R2: After five consecutive ones inside a frame, the next zero is removed. Octets are built from the remaining bits, with the first received bit as bit 0.
- R3: The last two complete octets of every frame are taken as the check sequence and are never written. All earlier octets appear on `wr_data_o` in arrival order, each with a one-cycle `wr_en_o`.
- R4: The check sequence is CRC-16 with reflected polynomial 0x8408 and preset 0xFFFF, sent complemented with the low octet first. A frame of legal length and alignment whose CRC register holds 0xF0B8 at the closing flag ends with status 3'b001.
- R5: A frame of legal length and alignment that fails the check ends with status 3'b011 and increments `fcs_err_cnt_o` by one.
- R6: A frame with fewer than 5 octets between flags, check sequence included, ends with status 3'b111 and leaves `fcs_err_cnt_o` unchanged. Its octets other than the final two are still written, and `msg_len_o` equals the number written. A 5-octet frame is legal.
- R7: A frame whose bit count between flags is not a multiple of eight ends with status 3'b111 and leaves `fcs_err_cnt_o` unchanged. Its complete octets except the final two are written, and the trailing partial octet is dropped.
- R8: Seven consecutive ones inside a frame that has data end it with status 3'b010. Bits received before the first flag, or after an abort until the next flag, cause no write and no interrupt.
- R9: Frame length has no upper bound. A frame with hundreds of octets is stored completely and reported with its full octet count.
- R10: `irq_o` pulses high for exactly one cycle at each message end. `status_o` changes only together with `irq_o`. `msg_len_o` counts written octets and holds until the first data bit of the next frame.
- R11: After reset, `wr_en_o` and `irq_o` are low, and `status_o`, `msg_len_o` and `fcs_err_cnt_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Qualifies `bit_i` for one cycle |
| bit_i | input | 1 | Serial line bit |
| wr_en_o | output | 1 | FIFO write strobe |
| wr_data_o | output | 8 | Octet to write |
| msg_len_o | output | LEN_W | Octets written for the current or last message |
| status_o | output | 3 | Status of last message: 001 good, 010 abort, 011 bad FCS, 111 invalid |
| irq_o | output | 1 | One-cycle pulse at message end |
| fcs_err_cnt_o | output | CNT_W | Count of check-sequence errors |

## Verification
The bench uses the default parameters: a 16-bit length, an 8-bit error counter and a 5-octet minimum. With a 16-bit length, a 300-octet frame can be counted without wrapping. The 8-bit counter stays below wrap for the number of corrupted frames sent. The 5-octet minimum puts the short/legal boundary at payload lengths of two and three octets, and both sides of that boundary are driven with good and corrupted check sequences. Random idle gaps on the bit enable show that only qualified bits advance the deframer.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  typedef enum logic [2:0] {
    ST_NONE    = 3'b000,
    ST_GOOD    = 3'b001,
    ST_ABORT   = 3'b010,
    ST_BADFCS  = 3'b011,
    ST_INVALID = 3'b111
  } rx_status_e;

  localparam logic [15:0] FCS_POLY_REFL = 16'h8408;
  localparam logic [15:0] FCS_PRESET    = 16'hFFFF;
  localparam logic [15:0] FCS_RESIDUE   = 16'hF0B8;
endpackage

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer #(
  parameter int unsigned FLAG_ONES = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic bit_i,
  output logic flag_o,
  output logic abort_o,
  output logic dat_vld_o,
  output logic dat_o
);
  localparam int unsigned ONES_W = $clog2(FLAG_ONES + 2);
  localparam int unsigned DLY    = FLAG_ONES;
  localparam int unsigned FILL_W = $clog2(DLY + 1);
  localparam logic [ONES_W-1:0] ONES_MAX  = ONES_W'(FLAG_ONES + 1);
  localparam logic [ONES_W-1:0] ONES_FLAG = ONES_W'(FLAG_ONES);
  localparam logic [ONES_W-1:0] ONES_STUF = ONES_W'(FLAG_ONES - 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(DLY);

  logic [ONES_W-1:0] ones_q;
  logic [DLY-1:0]    dl_q;
  logic [FILL_W-1:0] fill_q;
  logic              emit;

  // A stuffed zero (ones_q == FLAG_ONES-1) and the sixth one are never emitted
  assign emit    = bit_en_i && (ones_q < ONES_STUF);
  assign flag_o  = bit_en_i && !bit_i && (ones_q == ONES_FLAG);
  assign abort_o = bit_en_i &&  bit_i && (ones_q == ONES_FLAG);

  // Emitted bits wait DLY places so the leading flag bits never leave
  assign dat_vld_o = emit && (fill_q == FILL_FULL);
  assign dat_o     = dl_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q <= '0;
      dl_q   <= '0;
      fill_q <= '0;
    end else if (bit_en_i) begin
      if (bit_i) begin
        if (ones_q != ONES_MAX) ones_q <= ones_q + ONES_W'(1);
      end else begin
        ones_q <= '0;
      end
      if (flag_o || abort_o) begin
        fill_q <= '0;
      end else if (emit) begin
        dl_q <= {bit_i, dl_q[DLY-1:1]};
        if (fill_q != FILL_FULL) fill_q <= fill_q + FILL_W'(1);
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_fcs.sv
module hdlc_rx_fcs
  import hdlc_rx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        vld_i,
  input  logic        bit_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= FCS_PRESET;
    else if (init_i) crc_q <= FCS_PRESET;
    else if (vld_i)  crc_q <= (crc_q >> 1) ^ ((crc_q[0] ^ bit_i) ? FCS_POLY_REFL : 16'h0000);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/hdlc_rx_validator.sv
module hdlc_rx_validator
  import hdlc_rx_pkg::*;
#(
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned MIN_OCTETS = 5,
  parameter int unsigned FCS_OCTETS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             bit_i,
  output logic             wr_en_o,
  output logic [7:0]       wr_data_o,
  output logic [LEN_W-1:0] msg_len_o,
  output logic [2:0]       status_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] fcs_err_cnt_o
);
  localparam int unsigned HELD_W = $clog2(FCS_OCTETS + 1);
  localparam int unsigned TOT_W  = LEN_W + 1;
  localparam logic [HELD_W-1:0] HELD_FULL = HELD_W'(FCS_OCTETS);

  logic        flag_det, abort_det, dat_vld, dat;
  logic [15:0] crc;

  logic             in_frame_q, any_bits_q;
  logic [2:0]       bitcnt_q;
  logic [7:0]       sh_q;
  logic [7:0]       hold_q [FCS_OCTETS];
  logic [HELD_W-1:0] held_q;
  logic [LEN_W-1:0] len_q;
  logic [2:0]       status_q;
  logic             irq_q, wr_en_q;
  logic [7:0]       wr_data_q;
  logic [CNT_W-1:0] fcs_cnt_q;

  hdlc_rx_deframer #(.FLAG_ONES(6)) u_deframer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_en_i  (bit_en_i),
    .bit_i     (bit_i),
    .flag_o    (flag_det),
    .abort_o   (abort_det),
    .dat_vld_o (dat_vld),
    .dat_o     (dat)
  );

  logic take;
  assign take = dat_vld && in_frame_q;

  hdlc_rx_fcs u_fcs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (flag_det || abort_det),
    .vld_i  (take),
    .bit_i  (dat),
    .crc_o  (crc)
  );

  logic [7:0]       sh_n;
  logic             oct_done, is_short, misalign, msg_end, abort_end;
  logic [TOT_W-1:0] tot;
  rx_status_e       end_st;

  assign sh_n      = {dat, sh_q[7:1]};
  assign oct_done  = take && (bitcnt_q == 3'd7);
  assign tot       = TOT_W'(len_q) + TOT_W'(held_q);
  assign is_short  = tot < TOT_W'(MIN_OCTETS);
  assign misalign  = bitcnt_q != 3'd0;
  assign msg_end   = flag_det && in_frame_q && any_bits_q;
  assign abort_end = abort_det && in_frame_q && any_bits_q;

  always_comb begin
    if (is_short || misalign)    end_st = ST_INVALID;
    else if (crc != FCS_RESIDUE) end_st = ST_BADFCS;
    else                         end_st = ST_GOOD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      any_bits_q <= 1'b0;
      bitcnt_q   <= '0;
      sh_q       <= '0;
      held_q     <= '0;
      len_q      <= '0;
      status_q   <= ST_NONE;
      irq_q      <= 1'b0;
      wr_en_q    <= 1'b0;
      wr_data_q  <= '0;
      fcs_cnt_q  <= '0;
      for (int i = 0; i < FCS_OCTETS; i++) hold_q[i] <= '0;
    end else begin
      wr_en_q <= 1'b0;
      irq_q   <= 1'b0;
      if (flag_det) begin
        if (msg_end) begin
          status_q <= end_st;
          irq_q    <= 1'b1;
          if (end_st == ST_BADFCS) fcs_cnt_q <= fcs_cnt_q + CNT_W'(1);
        end
        in_frame_q <= 1'b1;
        any_bits_q <= 1'b0;
        bitcnt_q   <= '0;
        held_q     <= '0;
      end else if (abort_det) begin
        if (abort_end) begin
          status_q <= ST_ABORT;
          irq_q    <= 1'b1;
        end
        in_frame_q <= 1'b0;
        any_bits_q <= 1'b0;
        bitcnt_q   <= '0;
        held_q     <= '0;
      end else if (take) begin
        sh_q       <= sh_n;
        bitcnt_q   <= bitcnt_q + 3'd1;
        any_bits_q <= 1'b1;
        if (!any_bits_q) len_q <= '0;
        if (oct_done) begin
          // Newest FCS_OCTETS octets stay held; they may be the check sequence
          if (held_q == HELD_FULL) begin
            wr_en_q   <= 1'b1;
            wr_data_q <= hold_q[0];
            len_q     <= len_q + LEN_W'(1);
            for (int i = 0; i < FCS_OCTETS - 1; i++) hold_q[i] <= hold_q[i+1];
            hold_q[FCS_OCTETS-1] <= sh_n;
          end else begin
            for (int i = 0; i < FCS_OCTETS; i++)
              if (HELD_W'(i) == held_q) hold_q[i] <= sh_n;
            held_q <= held_q + HELD_W'(1);
          end
        end
      end
    end
  end

  assign wr_en_o       = wr_en_q;
  assign wr_data_o     = wr_data_q;
  assign msg_len_o     = len_q;
  assign status_o      = status_q;
  assign irq_o         = irq_q;
  assign fcs_err_cnt_o = fcs_cnt_q;
endmodule

// File: rtl/hdlc_rx_validator_chk.sv
module hdlc_rx_validator_chk #(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_o,
  input logic             irq_o,
  input logic [2:0]       status_o,
  input logic [LEN_W-1:0] msg_len_o,
  input logic [CNT_W-1:0] fcs_err_cnt_o
);
  p_irq_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_irq_status_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_o != 3'b000));

  p_status_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> $stable(status_o));

  p_fcs_cnt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcs_err_cnt_o != $past(fcs_err_cnt_o)) |-> (irq_o && status_o == 3'b011));

  p_wr_irq_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_o && irq_o));

  p_len_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (msg_len_o == $past(msg_len_o) + LEN_W'(1)));
endmodule

bind hdlc_rx_validator hdlc_rx_validator_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_o       (wr_en_o),
  .irq_o         (irq_o),
  .status_o      (status_o),
  .msg_len_o     (msg_len_o),
  .fcs_err_cnt_o (fcs_err_cnt_o)
);

// File: tb/hdlc_rx_validator_bench.sv
module hdlc_rx_validator_bench;
  localparam int LEN_W = 16;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic bit_v = 1'b0;
  logic             wr_en, irq;
  logic [7:0]       wr_data;
  logic [LEN_W-1:0] msg_len;
  logic [2:0]       status;
  logic [CNT_W-1:0] fcs_cnt;

  always #2 clk = ~clk;

  hdlc_rx_validator #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_hdlc_rx_validator (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .bit_i(bit_v),
    .wr_en_o(wr_en), .wr_data_o(wr_data), .msg_len_o(msg_len),
    .status_o(status), .irq_o(irq), .fcs_err_cnt_o(fcs_cnt));

  int checks = 0;
  int errors = 0;
  logic [7:0] pl [0:511];
  logic       fb [0:8191];
  int         fb_n;
  int         ones;
  logic [7:0] wbuf [0:511];
  int         wcount = 0;
  int         irq_cnt = 0;
  int         irq_double = 0;
  logic       irq_prev = 1'b0;
  logic [2:0] last_st = '0;
  logic [LEN_W-1:0] last_len = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        if (wcount < 512) wbuf[wcount] = wr_data;
        wcount++;
      end
      if (irq) begin
        irq_cnt++;
        last_st  = status;
        last_len = msg_len;
      end
      if (irq && irq_prev) irq_double++;
      irq_prev = irq;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fbk = r[0] ^ b[i];
      r = r >> 1;
      if (fbk) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  task automatic push_raw(input logic b);
    fb[fb_n] = b;
    fb_n++;
  endtask

  task automatic push_data(input logic b);
    push_raw(b);
    if (b) ones++; else ones = 0;
    if (ones == 5) begin
      push_raw(1'b0);
      ones = 0;
    end
  endtask

  task automatic push_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) push_data(v[i]);
  endtask

  task automatic push_flag();
    push_raw(1'b0);
    for (int i = 0; i < 6; i++) push_raw(1'b1);
    push_raw(1'b0);
    ones = 0;
  endtask

  task automatic send_buf();
    for (int i = 0; i < fb_n; i++) begin
      if ($urandom % 5 == 0) begin
        @(negedge clk);
        bit_en = 1'b0;
      end
      @(negedge clk);
      bit_en = 1'b1;
      bit_v  = fb[i];
    end
    @(negedge clk);
    bit_en = 1'b0;
    repeat (3) @(negedge clk);
    fb_n = 0;
  endtask

  // payload n octets, optional corrupt FCS, extra trailing bits, closing flag
  task automatic run_frame(input int n, input bit bad, input int extra, input string req);
    logic [15:0] c = 16'hFFFF;
    logic [15:0] fcs;
    int irq0, fcs0, mism;
    logic [2:0] exp_st;
    fb_n = 0;
    ones = 0;
    for (int i = 0; i < n; i++) begin
      push_byte(pl[i]);
      c = crc_upd(c, pl[i]);
    end
    fcs = ~c;
    if (bad) fcs = fcs ^ 16'h0100;
    push_byte(fcs[7:0]);
    push_byte(fcs[15:8]);
    for (int i = 0; i < extra; i++) push_data(1'($urandom));
    push_flag();
    wcount = 0;
    irq0 = irq_cnt;
    fcs0 = int'(fcs_cnt);
    send_buf();
    if (extra % 8 != 0 || n + 2 < 5) exp_st = 3'b111;
    else if (bad) exp_st = 3'b011;
    else exp_st = 3'b001;
    chk(irq_cnt == irq0 + 1, req, "irq count", irq_cnt - irq0, 1);
    chk(last_st == exp_st, req, "status", int'(last_st), int'(exp_st));
    chk(int'(last_len) == n, req, "length at irq", int'(last_len), n);
    chk(int'(msg_len) == n && status == exp_st, req, "length held", int'(msg_len), n);
    chk(wcount == n, req, "writes", wcount, n);
    mism = 0;
    for (int i = 0; i < n && i < wcount && i < 512; i++) if (wbuf[i] != pl[i]) mism++;
    chk(mism == 0, req, "written octets", mism, 0);
    chk(int'(fcs_cnt) == fcs0 + (exp_st == 3'b011 ? 1 : 0), req, "fcs error count",
        int'(fcs_cnt), fcs0 + (exp_st == 3'b011 ? 1 : 0));
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed, irq0;
    seed = $urandom(32'd20240611);
    fb_n = 0;
    ones = 0;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(!wr_en && !irq && status == 3'b000 && msg_len == '0 && fcs_cnt == '0,
        "R11", "reset outputs", int'(status), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8: bits before the first flag ignored
    for (int i = 0; i < 40; i++) push_raw(1'(i % 2));
    send_buf();
    chk(irq_cnt == 0 && wcount == 0, "R8", "pre-flag activity", irq_cnt + wcount, 0);

    // R1: back-to-back flags, no message
    push_flag(); push_flag(); push_flag();
    send_buf();
    chk(irq_cnt == 0 && wcount == 0, "R1", "idle flags", irq_cnt + wcount, 0);

    // R4 good frame
    for (int i = 0; i < 5; i++) pl[i] = 8'(8'h31 + i);
    run_frame(5, 1'b0, 0, "R4");
    // R2 stuffing with all-ones payload
    for (int i = 0; i < 6; i++) pl[i] = 8'hFF;
    run_frame(6, 1'b0, 0, "R2");
    pl[0] = 8'h7E; pl[1] = 8'hFE; pl[2] = 8'h3F; pl[3] = 8'h7C;
    run_frame(4, 1'b0, 0, "R2");
    // R5 bad FCS
    for (int i = 0; i < 4; i++) pl[i] = 8'(8'hA0 ^ i);
    run_frame(4, 1'b1, 0, "R5");
    // R6 boundary: 4 octets short, 5 octets legal
    pl[0] = 8'h12; pl[1] = 8'h34; pl[2] = 8'h56;
    run_frame(2, 1'b0, 0, "R6");
    run_frame(2, 1'b1, 0, "R6");
    run_frame(3, 1'b0, 0, "R6");
    run_frame(0, 1'b1, 0, "R6");
    // R7 misaligned
    for (int i = 0; i < 6; i++) pl[i] = 8'(8'h5A + 3 * i);
    run_frame(6, 1'b0, 3, "R7");
    run_frame(6, 1'b1, 7, "R7");
    // R9 long frame
    for (int i = 0; i < 300; i++) pl[i] = 8'($urandom);
    run_frame(300, 1'b0, 0, "R9");

    // R8 abort after 6 octets ending in a zero bit: 3 octets reach the FIFO
    for (int i = 0; i < 6; i++) pl[i] = 8'($urandom) & 8'h7F;
    fb_n = 0; ones = 0;
    for (int i = 0; i < 6; i++) push_byte(pl[i]);
    for (int i = 0; i < 12; i++) push_raw(1'b1);
    for (int i = 0; i < 24; i++) push_raw(1'(i % 2));
    wcount = 0;
    irq0 = irq_cnt;
    send_buf();
    chk(irq_cnt == irq0 + 1, "R8", "abort irq", irq_cnt - irq0, 1);
    chk(last_st == 3'b010, "R8", "abort status", int'(last_st), 2);
    chk(wcount == 3 && int'(last_len) == 3, "R8", "abort writes", wcount, 3);
    chk(wbuf[0] == pl[0] && wbuf[1] == pl[1] && wbuf[2] == pl[2], "R8", "abort octets",
        int'(wbuf[0]), int'(pl[0]));
    push_flag();
    send_buf();
    chk(irq_cnt == irq0 + 1, "R8", "post-abort bits ignored", irq_cnt - irq0, 1);

    // random mix
    for (int k = 0; k < 25; k++) begin
      int n = int'($urandom % 40);
      bit bad = 1'($urandom % 3 == 0);
      int ex = ($urandom % 4 == 0) ? int'(1 + $urandom % 7) : 0;
      for (int i = 0; i < n; i++) pl[i] = 8'($urandom);
      run_frame(n, bad, ex, "R3");
    end

    // R10 pulse width
    chk(irq_double == 0, "R10", "irq wider than one cycle", irq_double, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule